// File: doc/BRIEF.md
# Block-Granular Ring Buffer Controller

This block sits between a burst-oriented producer and a consumer that loads a whole block of words into parallel input registers at once. It manages a dual-port RAM as a ring of block slots. One RAM port only takes writes from the incoming bursts. The other port only reads toward the consumer. The controller keeps a write block pointer and a read block pointer, each with an extra wrap bit. A burst is granted only when a complete slot is free. A block is offered to the consumer only after every word of it has been written. Writing a later block and reading an earlier one can go on in the same cycles.

The producer holds `burst_req` and waits for `burst_gnt`. It then delivers `BLK_WORDS` words, one on each cycle in which `wr_valid` is high, and gaps between words are allowed. The consumer watches `blk_avail` and pulses `rd_start`. It then receives the oldest block at one word per cycle. When the RAM is full, grants stop. They resume in the cycle after the last word address of a block has been issued on the read port. `flush` empties the ring so that a new job can start.

Two small state machines run the block. The writer is in `WR_IDLE` or `WR_BURST`. It moves `WR_IDLE`→`WR_BURST` on a grant, and `WR_BURST`→`WR_IDLE` when the last word of the block is accepted or on flush. The reader is in `RD_IDLE` or `RD_STREAM`. It moves `RD_IDLE`→`RD_STREAM` when `rd_start` arrives while a block is available, and `RD_STREAM`→`RD_IDLE` when the last word address is issued or on flush. `NUM_SLOTS` (at least 2) and `BLK_WORDS` must be powers of two. The defaults are 64-bit words, 128 words per block and 4 slots.

Top module: `blkring_ctrl`

## Requirements
- R1: The number of committed blocks equals the write block pointer minus the read block pointer, where both pointers carry one wrap bit above the slot index. This number never exceeds `NUM_SLOTS`.
- R2: `burst_gnt` is high in a cycle only if all of these hold: the writer is idle, `burst_req` is high, `flush` is low, and fewer than `NUM_SLOTS` blocks are committed. Otherwise it is low, and in particular it stays low while the ring is full.
- R3: After a grant, the writer accepts exactly `BLK_WORDS` words on `wr_valid` cycles and stores them at consecutive offsets of the current slot. `wr_valid` is ignored while the writer is idle.
- R4: A block counts as committed, and becomes readable, only on the clock edge that accepts its last word.
- R5: `blk_avail` is high when the reader is idle, `flush` is low and at least one block is committed. `rd_start` while `blk_avail` is high starts a read of the oldest committed block. `rd_start` at any other time is ignored.
- R6: A read issues one word address per cycle for `BLK_WORDS` consecutive cycles. Each word appears on `rd_data` with `rd_valid` high exactly one cycle after its address is issued, in the order the words were written. `rd_last` is high together with the final word.
- R7: A slot is freed on the edge at which its last word address is issued. When that frees a full ring, a grant can be given in the very next cycle.
- R8: Reset (`rst_n` low, asynchronous) and `flush` (synchronous, high) empty the ring, abort any burst or read in progress, and hold `rd_valid`, `rd_last`, `blk_avail` and `burst_gnt` low in the following cycle.
- R9: Write and read addresses wrap from the last slot back to slot 0, and data stays correct across any number of wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Synchronous empty of the ring for a new job |
| burst_req | input | 1 | Producer asks to start a block burst |
| burst_gnt | output | 1 | A slot is free; the burst may start next cycle |
| wr_valid | input | 1 | Incoming word is valid |
| wr_data | input | DATA_W | Incoming word |
| rd_start | input | 1 | Consumer asks for the next block |
| blk_avail | output | 1 | A complete block is waiting and the reader is idle |
| rd_valid | output | 1 | `rd_data` holds a word of the block being read |
| rd_data | output | DATA_W | Word read from the ring |
| rd_last | output | 1 | Final word of the block |

## Verification
The bench builds the block with 16-bit words, 4-word blocks and 2 slots. With these values the ring fills after only two short bursts, so the full stall and its release are exercised within a few cycles. The same values make the pointers wrap many times and let a flush land in the middle of a burst and of a read. A behavioural queue model predicts grant, availability and every read word on each cycle, while `wr_valid` patterns with gaps and stray pulses outside bursts are applied.

// File: rtl/blkring_pkg.sv
package blkring_pkg;
    typedef enum logic {
        WR_IDLE,
        WR_BURST
    } wr_state_t;

    typedef enum logic {
        RD_IDLE,
        RD_STREAM
    } rd_state_t;
endpackage

// File: rtl/blkring_ram.sv
module blkring_ram #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // port A: write only
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // port B: registered read only
    always_ff @(posedge clk) begin
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/blkring_wr_fsm.sv
module blkring_wr_fsm
    import blkring_pkg::*;
#(
    parameter int BLK_WORDS = 128,
    parameter int SLOT_W    = 2,
    parameter int OFF_W     = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic                    burst_req,
    input  logic                    wr_valid,
    input  logic [SLOT_W:0]         rblk,
    output logic                    burst_gnt,
    output logic                    we,
    output logic                    commit,
    output logic [SLOT_W+OFF_W-1:0] waddr,
    output logic [SLOT_W:0]         wblk
);
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(BLK_WORDS - 1);

    wr_state_t        state, nxt;
    logic [OFF_W-1:0] woff;
    logic             full;

    // full: same slot index, opposite wrap bit
    assign full = (wblk[SLOT_W] != rblk[SLOT_W]) &&
                  (wblk[SLOT_W-1:0] == rblk[SLOT_W-1:0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     state <= WR_IDLE;
        else if (flush) state <= WR_IDLE;
        else            state <= nxt;
    end

    always_comb begin
        burst_gnt = 1'b0;
        we        = 1'b0;
        commit    = 1'b0;
        nxt       = state;
        unique case (state)
            WR_IDLE: begin
                burst_gnt = burst_req && !full && !flush;
                if (burst_gnt) nxt = WR_BURST;
            end
            WR_BURST: begin
                we     = wr_valid && !flush;
                commit = we && (woff == LAST_OFF);
                if (commit) nxt = WR_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            woff <= '0;
            wblk <= '0;
        end else if (flush) begin
            woff <= '0;
            wblk <= '0;
        end else begin
            if (we)     woff <= commit ? '0 : woff + 1'b1;
            if (commit) wblk <= wblk + 1'b1;
        end
    end

    assign waddr = {wblk[SLOT_W-1:0], woff};
endmodule

// File: rtl/blkring_rd_fsm.sv
module blkring_rd_fsm
    import blkring_pkg::*;
#(
    parameter int BLK_WORDS = 128,
    parameter int SLOT_W    = 2,
    parameter int OFF_W     = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic                    rd_start,
    input  logic [SLOT_W:0]         wblk,
    output logic                    blk_avail,
    output logic                    ren,
    output logic                    release_blk,
    output logic [SLOT_W+OFF_W-1:0] raddr,
    output logic [SLOT_W:0]         rblk,
    output logic                    rd_valid,
    output logic                    rd_last
);
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(BLK_WORDS - 1);

    rd_state_t        state, nxt;
    logic [OFF_W-1:0] roff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     state <= RD_IDLE;
        else if (flush) state <= RD_IDLE;
        else            state <= nxt;
    end

    always_comb begin
        blk_avail   = 1'b0;
        ren         = 1'b0;
        release_blk = 1'b0;
        nxt         = state;
        unique case (state)
            RD_IDLE: begin
                blk_avail = (wblk != rblk) && !flush;
                if (blk_avail && rd_start) nxt = RD_STREAM;
            end
            RD_STREAM: begin
                ren         = !flush;
                release_blk = ren && (roff == LAST_OFF);
                if (release_blk) nxt = RD_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            roff     <= '0;
            rblk     <= '0;
            rd_valid <= 1'b0;
            rd_last  <= 1'b0;
        end else if (flush) begin
            roff     <= '0;
            rblk     <= '0;
            rd_valid <= 1'b0;
            rd_last  <= 1'b0;
        end else begin
            if (ren)         roff <= release_blk ? '0 : roff + 1'b1;
            if (release_blk) rblk <= rblk + 1'b1;
            rd_valid <= ren;
            rd_last  <= release_blk;
        end
    end

    assign raddr = {rblk[SLOT_W-1:0], roff};
endmodule

// File: rtl/blkring_ctrl.sv
module blkring_ctrl #(
    parameter int DATA_W    = 64,
    parameter int BLK_WORDS = 128,
    parameter int NUM_SLOTS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              burst_req,
    output logic              burst_gnt,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_start,
    output logic              blk_avail,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_last
);
    localparam int SLOT_W = $clog2(NUM_SLOTS);
    localparam int OFF_W  = $clog2(BLK_WORDS);
    localparam int ADDR_W = SLOT_W + OFF_W;

    logic [SLOT_W:0]   wblk, rblk;
    logic              we, ren, commit, release_blk;
    logic [ADDR_W-1:0] waddr, raddr;

    blkring_wr_fsm #(.BLK_WORDS(BLK_WORDS), .SLOT_W(SLOT_W), .OFF_W(OFF_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .flush(flush), .burst_req(burst_req),
        .wr_valid(wr_valid), .rblk(rblk), .burst_gnt(burst_gnt), .we(we),
        .commit(commit), .waddr(waddr), .wblk(wblk)
    );

    blkring_rd_fsm #(.BLK_WORDS(BLK_WORDS), .SLOT_W(SLOT_W), .OFF_W(OFF_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .flush(flush), .rd_start(rd_start),
        .wblk(wblk), .blk_avail(blk_avail), .ren(ren), .release_blk(release_blk),
        .raddr(raddr), .rblk(rblk), .rd_valid(rd_valid), .rd_last(rd_last)
    );

    blkring_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .clk(clk), .we(we), .waddr(waddr), .wdata(wr_data),
        .re(ren), .raddr(raddr), .rdata(rd_data)
    );
endmodule

module blkring_ctrl_chk #(
    parameter int SLOT_W    = 2,
    parameter int NUM_SLOTS = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            flush,
    input logic            burst_gnt,
    input logic            blk_avail,
    input logic            rd_valid,
    input logic            ren,
    input logic            commit,
    input logic            release_blk,
    input logic [SLOT_W:0] wblk,
    input logic [SLOT_W:0] rblk
);
    localparam int CW = SLOT_W + 2;
    localparam logic [CW-1:0] CAP = CW'(NUM_SLOTS);

    logic [CW-1:0]   cnt;
    logic [SLOT_W:0] ptr_diff;

    assign ptr_diff = wblk - rblk;

    // independent block count from commit/release events
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (flush) cnt <= '0;
        else if (commit && !release_blk) cnt <= cnt + 1'b1;
        else if (release_blk && !commit) cnt <= cnt - 1'b1;
    end

    a_r1_count_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        cnt == {1'b0, ptr_diff});

    a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CAP);

    a_r2_gnt_room: assert property (@(posedge clk) disable iff (!rst_n)
        burst_gnt |-> (cnt < CAP));

    a_r5_avail_has_block: assert property (@(posedge clk) disable iff (!rst_n)
        blk_avail |-> (cnt != '0));

    a_r6_valid_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(ren));

    a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cnt == '0 && !rd_valid));
endmodule

bind blkring_ctrl blkring_ctrl_chk #(.SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .burst_gnt(burst_gnt),
    .blk_avail(blk_avail), .rd_valid(rd_valid), .ren(ren), .commit(commit),
    .release_blk(release_blk), .wblk(wblk), .rblk(rblk)
);

// File: tb/blkring_ctrl_test.sv
module blkring_ctrl_test;
    localparam int DW = 16;
    localparam int BW = 4;
    localparam int NS = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic          burst_req = 1'b0;
    logic          wr_valid = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_start = 1'b0;
    logic          burst_gnt, blk_avail, rd_valid, rd_last;
    logic [DW-1:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    blkring_ctrl #(.DATA_W(DW), .BLK_WORDS(BW), .NUM_SLOTS(NS)) uut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .burst_req(burst_req),
        .burst_gnt(burst_gnt), .wr_valid(wr_valid), .wr_data(wr_data),
        .rd_start(rd_start), .blk_avail(blk_avail), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_last(rd_last)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural model
    int            m_occ, m_woff, m_roff, nread;
    bit            m_wbusy, m_rbusy, m_pv, m_pl;
    logic [DW-1:0] m_pd;
    logic [DW-1:0] ringq[$];
    logic [DW-1:0] cur[$];
    bit            e_gnt, e_av;

    task automatic model_clear();
        m_occ = 0; m_woff = 0; m_roff = 0;
        m_wbusy = 0; m_rbusy = 0; m_pv = 0; m_pl = 0;
        ringq.delete(); cur.delete();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        model_clear();
        nread = 0;
        for (int cyc = 0; cyc < 760; cyc++) begin
            @(negedge clk);
            rst_n = (cyc >= 4);
            flush = (cyc == 420) || (cyc == 601);
            // stimulus phases
            if (cyc < 4) begin
                burst_req = 0; wr_valid = 0; rd_start = 0;
            end else if (cyc < 40) begin
                // R2: fill to full with no reader; R3: wr_valid also high when idle
                burst_req = 1; wr_valid = 1; rd_start = 0;
            end else if (cyc < 500) begin
                burst_req = 1; wr_valid = (cyc % 3 != 1); rd_start = (cyc % 7 < 5);
            end else begin
                burst_req = (cyc % 5 == 0) || m_wbusy; wr_valid = (cyc % 4 != 0);
                rd_start = 1;
            end
            wr_data = DW'(cyc * 37 + 5);
            e_gnt = !flush && !m_wbusy && burst_req && (m_occ < NS);
            e_av  = !flush && !m_rbusy && (m_occ > 0);
            #1;
            if (cyc == 2) begin
                // R8: reset state
                chk("R8 reset rd_valid", rd_valid, 0);
                chk("R8 reset blk_avail", blk_avail, 0);
                chk("R8 reset burst_gnt", burst_gnt, 0);
            end
            if (rst_n) begin
                // R2 and R7: grant timing including release of a full ring
                chk("R2 burst_gnt", burst_gnt, e_gnt);
                // R5: availability, R4: only committed blocks count
                chk("R5 blk_avail", blk_avail, e_av);
                // R6 and R8: read valid timing and flush clearing
                chk("R6 rd_valid", rd_valid, m_pv);
                if (m_pv) begin
                    // R3, R4, R9: data order and content across wraps
                    chk("R3 rd_data", rd_data, m_pd);
                    chk("R6 rd_last", rd_last, m_pl);
                end
            end
            if (cyc == 39) begin
                // R1: ring holds exactly NS blocks and no more grants
                chk("R1 full occupancy", m_occ, NS);
                chk("R2 full no grant", burst_gnt, 0);
            end
            @(posedge clk);
            if (!rst_n || flush) begin
                model_clear();
            end else begin
                m_pv = m_rbusy;
                m_pl = 0;
                if (m_rbusy) begin
                    m_pd = ringq.pop_front();
                    m_roff++;
                    if (m_roff == BW) begin
                        m_pl = 1; m_rbusy = 0; m_roff = 0; m_occ--; nread++;
                    end
                end else if (rd_start && e_av) begin
                    m_rbusy = 1;
                end
                if (m_wbusy && wr_valid) begin
                    cur.push_back(wr_data);
                    m_woff++;
                    if (m_woff == BW) begin
                        foreach (cur[i]) ringq.push_back(cur[i]);
                        cur.delete();
                        m_occ++; m_wbusy = 0; m_woff = 0;
                    end
                end else if (e_gnt) begin
                    m_wbusy = 1;
                end
            end
        end
        // R9: many blocks passed through a two-slot ring
        chk("R9 wrap count", (nread > 4 * NS) ? 1 : 0, 1);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule